// File: doc/BRIEF.md
# Display Power-Up Initialisation Sequencer

This block brings a page-addressed monochrome display controller out of reset and into a known configuration. On a start pulse it first drives the panel's reset line for a fixed time. It then releases the line and waits the same time again. After that it feeds a fixed, ordered list of configuration commands, one byte at a time, into a command-byte transport. Steps that a feature flag does not select are skipped. When the last byte has been accepted, the block raises `done`. Only then may the surrounding logic push the first frame and the display-on opcode (0xAF); display-off is 0xAE.

Every option byte is built from separate configuration fields: panel height, COM offset, clock divider and oscillator setting, precharge phases, COM pin options, VCOMH level, charge-pump need and an optional gamma lookup table. The reset hold time is given in microseconds and turned into clock cycles from the clock frequency parameter. A transport error on any byte ends the run at once with `fail`.

Top module: `disp_init_seq`

## Requirements
- R1: After `start`, `panel_rst` is high for exactly RST_CYC = (CLK_HZ/1e6)·RST_US cycles, then low for exactly RST_CYC cycles, and no command byte is offered before that. While idle, `panel_rst`, `cmd_valid`, `done` and `fail` are low.
- R2: The first bytes are 0x81 and then the contrast. They are followed by 0xA1, but only when segment remap is enabled. Next comes a single COM scan byte: 0xC0, or 0xC4 (bit 2 set) when the scan is inverted.
- R3: Next come 0xA8 with height−1, then 0xD3 with the COM offset, then 0xD5 with an option byte that holds (divider−1) in bits 3:0 and the oscillator setting in bits 7:4.
- R4: 0xD8 and its option byte are sent only when area colour or low power is enabled. The option is 0x1E (if area colour) ORed with 0x05 (if low power).
- R5: 0xD9 is then sent, with phase 1 in bits 3:0 and phase 2 in bits 7:4. After it comes 0xDA with an option of 0x02, plus 0x10 when sequential COM is off, plus 0x20 when left/right remap is on.
- R6: Then 0xDB with the VCOMH level is sent, followed by 0x8D with 0x10, or with 0x14 when the charge pump is required.
- R7: With the lookup table enabled, 0x91 is sent, followed by each of the LUT_LEN entries as its own byte, entry 0 (bits 7:0 of `cfg_lut`) first. `lut_warn` is high after the run if any sent entry was below 31 or above 63. It is cleared by `start`.
- R8: The sequence ends with 0x20 and then 0x00. On the cycle after that last byte is accepted, `done` goes high and no further byte is offered.
- R9: With `cfg_use_dflt` high, the contrast sent is 127 and both precharge phases are 2 (option 0x22), whatever the contrast and phase inputs hold.
- R10: A byte offered while `cmd_ready` is low stays offered, unchanged, until it is accepted.
- R11: A byte accepted with `cmd_err` high ends the run: `fail` goes high on the next cycle, `done` stays low and no further byte is offered. A later `start` begins a full new run.
- R12: `start` is ignored while the sequencer is busy. The byte stream continues unchanged and no new reset pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (idle, done or failed only) |
| cfg_use_dflt | input | 1 | Use default contrast and precharge |
| cfg_contrast | input | 8 | Contrast level |
| cfg_seg_remap | input | 1 | Send segment remap step |
| cfg_com_inv | input | 1 | Inverted COM scan direction |
| cfg_height | input | 8 | Panel height in rows |
| cfg_com_ofs | input | 8 | COM display offset |
| cfg_clk_div | input | 5 | Clock divider, 1 to 16 |
| cfg_clk_frq | input | 4 | Oscillator setting |
| cfg_area_color | input | 1 | Area colour enable |
| cfg_low_power | input | 1 | Low-power mode enable |
| cfg_pre1 | input | 4 | Precharge phase 1 |
| cfg_pre2 | input | 4 | Precharge phase 2 |
| cfg_com_seq | input | 1 | Sequential COM pin layout |
| cfg_com_lr | input | 1 | COM left/right remap |
| cfg_vcomh | input | 8 | VCOMH level |
| cfg_pump | input | 1 | Charge pump required |
| cfg_lut_en | input | 1 | Send the lookup table |
| cfg_lut | input | 8·LUT_LEN | Lookup table entries, entry 0 in bits 7:0 |
| cmd_ready | input | 1 | Transport accepts the offered byte |
| cmd_err | input | 1 | Transport error on the accepted byte |
| cmd_valid | output | 1 | A command byte is offered |
| cmd_byte | output | 8 | Offered command byte |
| panel_rst | output | 1 | Panel reset line, active high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| fail | output | 1 | Sequence stopped on a transport error |
| lut_warn | output | 1 | A lookup entry was out of range |

## Verification
A wrong step index or a bad skip decision shows at the ports as a wrong or missing byte. It appears at the very next handshake, because every offered byte is compared with a queue built from the requirements. A mistimed reset counter shows as a wrong length of the high or low phase of `panel_rst`, and the length of each phase is counted to the exact cycle. A state that fails to stop or finish shows within one cycle as `cmd_valid` after `fail` or `done`, or as `done` missing once the expected queue is empty.

// File: rtl/disp_init_pkg.sv
// Shared opcodes, defaults, state and configuration types for the
// display initialisation sequencer. Assumes 8-bit command bytes.
package disp_init_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_HOLD, S_GAP, S_SEND, S_DONE, S_FAIL
    } seq_state_t;

    localparam logic [7:0] OP_CONTRAST = 8'h81;
    localparam logic [7:0] OP_SEGREMAP = 8'hA1;
    localparam logic [7:0] OP_COMSCAN  = 8'hC0;
    localparam logic [7:0] OP_MUX      = 8'hA8;
    localparam logic [7:0] OP_DOFS     = 8'hD3;
    localparam logic [7:0] OP_CLK      = 8'hD5;
    localparam logic [7:0] OP_AREA     = 8'hD8;
    localparam logic [7:0] OP_PRECH    = 8'hD9;
    localparam logic [7:0] OP_COMPINS  = 8'hDA;
    localparam logic [7:0] OP_VCOMH    = 8'hDB;
    localparam logic [7:0] OP_PUMP     = 8'h8D;
    localparam logic [7:0] OP_LUT      = 8'h91;
    localparam logic [7:0] OP_ADDRMODE = 8'h20;
    localparam logic [7:0] ADDR_HORIZ  = 8'h00;

    localparam logic [7:0] AREA_BITS    = 8'h1E;
    localparam logic [7:0] LOWP_BITS    = 8'h05;
    localparam logic [7:0] DEF_CONTRAST = 8'd127;
    localparam logic [3:0] DEF_PRECH    = 4'd2;
    localparam logic [7:0] LUT_MIN      = 8'd31;
    localparam logic [7:0] LUT_MAX      = 8'd63;

    // Slots before the lookup entries; two address-mode slots follow them.
    localparam int HEAD_SLOTS = 21;
    localparam int TAIL_SLOTS = 2;

    typedef struct packed {
        logic [7:0] contrast;
        logic       seg_remap;
        logic       com_inv;
        logic [7:0] height;
        logic [7:0] com_ofs;
        logic [4:0] clk_div;
        logic [3:0] clk_frq;
        logic       area_color;
        logic       low_power;
        logic [3:0] pre1;
        logic [3:0] pre2;
        logic       com_seq;
        logic       com_lr;
        logic [7:0] vcomh;
        logic       pump;
        logic       lut_en;
    } disp_cfg_t;

endpackage

// File: rtl/disp_rst_timer.sv
// Cycle timer for the panel reset phases. While run is high it counts
// up and flags expiry on the LIMIT-th cycle, then wraps to zero so the
// next phase is timed back to back. Assumes LIMIT >= 1.
module disp_rst_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    // Count while running, wrap on expiry, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    // R1: the phase counter never passes its limit
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/disp_cmd_rom.sv
// Maps a step index to the command byte of that step, plus an enable
// that says whether the step is sent with this configuration. The
// option bytes are assembled here from the configuration fields.
// Assumes the configuration is stable for the whole run.
module disp_cmd_rom
    import disp_init_pkg::*;
#(
    parameter int LUT_LEN = 4,
    parameter int IDX_W   = 5
) (
    input  disp_cfg_t            cfg,
    input  logic [8*LUT_LEN-1:0] lut_flat,
    input  logic [IDX_W-1:0]     idx,
    output logic                 slot_en,
    output logic [7:0]           slot_byte,
    output logic                 slot_is_lut
);
    logic [7:0] lut_arr [LUT_LEN];
    logic [4:0] div_m1;
    logic       area_on;

    for (genvar g = 0; g < LUT_LEN; g++) begin : g_unpack
        assign lut_arr[g] = lut_flat[8*g +: 8];
    end

    assign div_m1  = cfg.clk_div - 5'd1;
    assign area_on = cfg.area_color || cfg.low_power;

    // Pick the byte and enable of the current step.
    always_comb begin
        slot_en     = 1'b1;
        slot_byte   = 8'h00;
        slot_is_lut = 1'b0;
        case (int'(idx))
            0:  slot_byte = OP_CONTRAST;
            1:  slot_byte = cfg.contrast;
            2:  begin slot_byte = OP_SEGREMAP; slot_en = cfg.seg_remap; end
            3:  slot_byte = OP_COMSCAN | {5'b0, cfg.com_inv, 2'b0};
            4:  slot_byte = OP_MUX;
            5:  slot_byte = cfg.height - 8'd1;
            6:  slot_byte = OP_DOFS;
            7:  slot_byte = cfg.com_ofs;
            8:  slot_byte = OP_CLK;
            9:  slot_byte = {cfg.clk_frq, div_m1[3:0]};
            10: begin slot_byte = OP_AREA; slot_en = area_on; end
            11: begin
                    slot_byte = (cfg.area_color ? AREA_BITS : 8'h00)
                              | (cfg.low_power  ? LOWP_BITS : 8'h00);
                    slot_en   = area_on;
                end
            12: slot_byte = OP_PRECH;
            13: slot_byte = {cfg.pre2, cfg.pre1};
            14: slot_byte = OP_COMPINS;
            15: slot_byte = {2'b00, cfg.com_lr, !cfg.com_seq, 4'b0010};
            16: slot_byte = OP_VCOMH;
            17: slot_byte = cfg.vcomh;
            18: slot_byte = OP_PUMP;
            19: slot_byte = {5'b00010, cfg.pump, 2'b00};
            20: begin slot_byte = OP_LUT; slot_en = cfg.lut_en; end
            default: begin
                if (int'(idx) == HEAD_SLOTS + LUT_LEN) slot_byte = OP_ADDRMODE;
                else                                   slot_byte = ADDR_HORIZ;
                for (int i = 0; i < LUT_LEN; i++) begin
                    if (int'(idx) == HEAD_SLOTS + i) begin
                        slot_byte   = lut_arr[i];
                        slot_en     = cfg.lut_en;
                        slot_is_lut = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/disp_init_seq.sv
// Power-up sequencer: on start it pulses the panel reset line, waits,
// then walks the command steps, skipping disabled ones, offering each
// byte on a valid/ready transport. It ends in done, or in fail on a
// transport error. Assumes configuration inputs stay stable while busy.
module disp_init_seq
    import disp_init_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int RST_US    = 4,
    parameter bit HAS_RESET = 1'b1,
    parameter int LUT_LEN   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_use_dflt,
    input  logic [7:0]           cfg_contrast,
    input  logic                 cfg_seg_remap,
    input  logic                 cfg_com_inv,
    input  logic [7:0]           cfg_height,
    input  logic [7:0]           cfg_com_ofs,
    input  logic [4:0]           cfg_clk_div,
    input  logic [3:0]           cfg_clk_frq,
    input  logic                 cfg_area_color,
    input  logic                 cfg_low_power,
    input  logic [3:0]           cfg_pre1,
    input  logic [3:0]           cfg_pre2,
    input  logic                 cfg_com_seq,
    input  logic                 cfg_com_lr,
    input  logic [7:0]           cfg_vcomh,
    input  logic                 cfg_pump,
    input  logic                 cfg_lut_en,
    input  logic [8*LUT_LEN-1:0] cfg_lut,
    input  logic                 cmd_ready,
    input  logic                 cmd_err,
    output logic                 cmd_valid,
    output logic [7:0]           cmd_byte,
    output logic                 panel_rst,
    output logic                 busy,
    output logic                 done,
    output logic                 fail,
    output logic                 lut_warn
);
    localparam int RST_CYC = (CLK_HZ / 1_000_000) * RST_US;
    localparam int NSLOT   = HEAD_SLOTS + LUT_LEN + TAIL_SLOTS;
    localparam int IDX_W   = $clog2(NSLOT);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             warn_q;
    disp_cfg_t        cfg;
    logic             slot_en, slot_is_lut, tmr_exp, accept, lut_bad;
    logic [7:0]       slot_byte;

    // Gather the configuration, applying defaults when asked.
    always_comb begin
        cfg            = '0;
        cfg.contrast   = cfg_use_dflt ? DEF_CONTRAST : cfg_contrast;
        cfg.seg_remap  = cfg_seg_remap;
        cfg.com_inv    = cfg_com_inv;
        cfg.height     = cfg_height;
        cfg.com_ofs    = cfg_com_ofs;
        cfg.clk_div    = cfg_clk_div;
        cfg.clk_frq    = cfg_clk_frq;
        cfg.area_color = cfg_area_color;
        cfg.low_power  = cfg_low_power;
        cfg.pre1       = cfg_use_dflt ? DEF_PRECH : cfg_pre1;
        cfg.pre2       = cfg_use_dflt ? DEF_PRECH : cfg_pre2;
        cfg.com_seq    = cfg_com_seq;
        cfg.com_lr     = cfg_com_lr;
        cfg.vcomh      = cfg_vcomh;
        cfg.pump       = cfg_pump;
        cfg.lut_en     = cfg_lut_en;
    end

    disp_cmd_rom #(.LUT_LEN(LUT_LEN), .IDX_W(IDX_W)) u_rom (
        .cfg        (cfg),
        .lut_flat   (cfg_lut),
        .idx        (idx_q),
        .slot_en    (slot_en),
        .slot_byte  (slot_byte),
        .slot_is_lut(slot_is_lut)
    );

    disp_rst_timer #(.LIMIT(RST_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == S_HOLD || state_q == S_GAP),
        .expired(tmr_exp)
    );

    assign cmd_valid = (state_q == S_SEND) && slot_en;
    assign cmd_byte  = slot_byte;
    assign accept    = cmd_valid && cmd_ready;
    assign lut_bad   = slot_is_lut && (slot_byte < LUT_MIN || slot_byte > LUT_MAX);
    assign panel_rst = (state_q == S_HOLD);
    assign busy      = (state_q == S_HOLD) || (state_q == S_GAP) || (state_q == S_SEND);
    assign done      = (state_q == S_DONE);
    assign fail      = (state_q == S_FAIL);
    assign lut_warn  = warn_q;

    // Sequence state, step index and lookup warning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            warn_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE, S_DONE, S_FAIL: begin
                    if (start) begin
                        idx_q   <= '0;
                        warn_q  <= 1'b0;
                        state_q <= HAS_RESET ? S_HOLD : S_SEND;
                    end
                end
                S_HOLD: if (tmr_exp) state_q <= S_GAP;
                S_GAP:  if (tmr_exp) state_q <= S_SEND;
                S_SEND: begin
                    if (!slot_en) begin
                        if (idx_q == LAST_IDX) state_q <= S_DONE;
                        else                   idx_q   <= idx_q + 1'b1;
                    end else if (accept) begin
                        if (lut_bad) warn_q <= 1'b1;
                        if (cmd_err)                state_q <= S_FAIL;
                        else if (idx_q == LAST_IDX) state_q <= S_DONE;
                        else                        idx_q   <= idx_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R1: no command byte while the panel is held in reset
    a_r1_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        panel_rst |-> !cmd_valid);

    // R10: an unaccepted byte stays offered and unchanged
    a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte)));

    // R11: a transport error stops the run
    a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_err) |=> (fail && !cmd_valid && !done));

    // R8: done excludes fail and busy
    a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(fail || busy || cmd_valid));

    // R12: start during a transfer does not restart the reset pulse
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && start) |=> !panel_rst);

endmodule

// File: tb/disp_init_seq_test.sv
`timescale 1ns/1ps
module disp_init_seq_test;
    localparam int LUT_LEN = 4;
    localparam int RST_CYC = 250 * 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic use_dflt = 0, seg = 0, inv = 0, ac = 0, lp = 0, seq = 0, lr = 0, pump = 0, lut_en = 0;
    logic [7:0] contrast = 0, height = 8'd64, ofs = 0, vcomh = 0;
    logic [4:0] div = 5'd1;
    logic [3:0] frq = 0, pre1 = 0, pre2 = 0;
    logic [8*LUT_LEN-1:0] lut = '0;
    logic cmd_ready = 0, cmd_err = 0;
    logic cmd_valid, panel_rst, busy, done, fail, lut_warn;
    logic [7:0] cmd_byte;

    int checks = 0, errors = 0;
    logic [7:0] q[$];
    logic exp_warn;

    always #2 clk = ~clk;

    disp_init_seq #(.CLK_HZ(250_000_000), .RST_US(4), .HAS_RESET(1'b1), .LUT_LEN(LUT_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_use_dflt(use_dflt),
        .cfg_contrast(contrast), .cfg_seg_remap(seg), .cfg_com_inv(inv),
        .cfg_height(height), .cfg_com_ofs(ofs), .cfg_clk_div(div), .cfg_clk_frq(frq),
        .cfg_area_color(ac), .cfg_low_power(lp), .cfg_pre1(pre1), .cfg_pre2(pre2),
        .cfg_com_seq(seq), .cfg_com_lr(lr), .cfg_vcomh(vcomh), .cfg_pump(pump),
        .cfg_lut_en(lut_en), .cfg_lut(lut), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .panel_rst(panel_rst), .busy(busy),
        .done(done), .fail(fail), .lut_warn(lut_warn));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Behavioural model: the expected byte stream for the current settings.
    task automatic build_expected();
        int c, p1, p2, v;
        q.delete();
        exp_warn = 1'b0;
        c  = use_dflt ? 127 : int'(contrast);
        p1 = use_dflt ? 2 : int'(pre1);
        p2 = use_dflt ? 2 : int'(pre2);
        q.push_back(8'h81); q.push_back(8'(c));
        if (seg) q.push_back(8'hA1);
        q.push_back(inv ? 8'hC4 : 8'hC0);
        q.push_back(8'hA8); q.push_back(8'(int'(height) - 1));
        q.push_back(8'hD3); q.push_back(ofs);
        q.push_back(8'hD5); q.push_back(8'(int'(frq) * 16 + ((int'(div) - 1) % 16)));
        if (ac || lp) begin
            q.push_back(8'hD8);
            q.push_back(8'((ac ? 30 : 0) | (lp ? 5 : 0)));
        end
        q.push_back(8'hD9); q.push_back(8'(p2 * 16 + p1));
        q.push_back(8'hDA); q.push_back(8'(2 + (seq ? 0 : 16) + (lr ? 32 : 0)));
        q.push_back(8'hDB); q.push_back(vcomh);
        q.push_back(8'h8D); q.push_back(pump ? 8'h14 : 8'h10);
        if (lut_en) begin
            q.push_back(8'h91);
            for (int i = 0; i < LUT_LEN; i++) begin
                v = int'(lut[8*i +: 8]);
                q.push_back(8'(v));
                if (v < 31 || v > 63) exp_warn = 1'b1;
            end
        end
        q.push_back(8'h20); q.push_back(8'h00);
    endtask

    // Run one sequence, comparing the ports with the model every clock.
    task automatic run_seq(input bit stall, input int err_at, input string name);
        int hi = 0, lo = 0, n_acc = 0, guard = 0;
        bit acc, was_wait, hit_err;
        logic [7:0] held;
        build_expected();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (panel_rst && hi < 5000) begin hi++; @(negedge clk); end
        chk(hi == RST_CYC, {"R1 reset high length ", name}, hi, RST_CYC);
        while (!panel_rst && !cmd_valid && lo < 5000) begin lo++; @(negedge clk); end
        chk(lo == RST_CYC, {"R1 reset gap length ", name}, lo, RST_CYC);
        was_wait = 0; hit_err = 0; held = 0;
        while (guard < 3000) begin
            guard++;
            if (was_wait) chk(cmd_valid && cmd_byte == held, {"R10 byte held ", name},
                              int'(cmd_byte), int'(held));
            if (cmd_valid) chk(cmd_byte == q[0], {"R2/R3/R4/R5/R6/R7/R8 byte order ", name},
                               int'(cmd_byte), int'(q[0]));
            if (guard > 1) chk(!panel_rst, {"R12 no new reset ", name}, int'(panel_rst), 0);
            cmd_ready = stall ? ((guard % 3) != 0) : 1'b1;
            cmd_err   = cmd_valid && cmd_ready && (n_acc == err_at);
            start     = (guard == 5);
            acc       = cmd_valid && cmd_ready;
            was_wait  = cmd_valid && !cmd_ready;
            held      = cmd_byte;
            hit_err   = cmd_err;
            @(negedge clk);
            start = 1'b0; cmd_err = 1'b0; cmd_ready = 1'b0;
            if (acc) begin
                void'(q.pop_front());
                n_acc++;
                if (hit_err) break;
                if (q.size() == 0) break;
            end
        end
        if (hit_err) begin
            chk(fail == 1'b1, {"R11 fail raised ", name}, int'(fail), 1);
            chk(done == 1'b0 && cmd_valid == 1'b0, {"R11 stopped ", name},
                int'({done, cmd_valid}), 0);
            repeat (3) @(negedge clk);
            chk(cmd_valid == 1'b0 && fail == 1'b1, {"R11 stays stopped ", name},
                int'({fail, cmd_valid}), 2);
        end else begin
            chk(q.size() == 0, {"R8 all bytes sent ", name}, q.size(), 0);
            chk(done == 1'b1 && fail == 1'b0, {"R8 done raised ", name},
                int'({done, fail}), 2);
            chk(lut_warn == exp_warn, {"R7 lookup warning ", name},
                int'(lut_warn), int'(exp_warn));
            @(negedge clk);
            chk(cmd_valid == 1'b0 && done == 1'b1, {"R8 quiet after done ", name},
                int'({done, cmd_valid}), 2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!panel_rst && !cmd_valid && !done && !fail, "R1 idle after reset",
            int'({panel_rst, cmd_valid, done, fail}), 0);

        // Plain setup: optional steps off, R2 R3 R5 R6 fields
        contrast = 8'h5A; height = 8'd64; ofs = 8'd0; div = 5'd1; frq = 4'd8;
        pre1 = 4'd1; pre2 = 4'd15; vcomh = 8'h20; pump = 1;
        run_seq(1'b0, -1, "plain");

        // Every option on, defaults (R9), out-of-range table (R7), stalls (R10)
        use_dflt = 1; contrast = 8'h10; pre1 = 4'd7; pre2 = 4'd7;
        seg = 1; inv = 1; ac = 1; lp = 1; lut_en = 1; seq = 1; lr = 1; pump = 0;
        height = 8'd16; ofs = 8'd5; div = 5'd16; frq = 4'd15; vcomh = 8'h34;
        lut = {8'd64, 8'd63, 8'd31, 8'd10};
        run_seq(1'b1, -1, "full");

        // Area colour only, table in range: R4 R7 warning cleared
        use_dflt = 0; seg = 0; inv = 0; lp = 0; lr = 0; pump = 1; div = 5'd2;
        lut = {8'd31, 8'd60, 8'd50, 8'd40};
        run_seq(1'b1, -1, "area");

        // Low power only with a transport error on the 8th byte: R11
        ac = 0; lp = 1; lut_en = 0;
        run_seq(1'b0, 7, "error");

        // Restart after failure runs the full sequence again
        lp = 0; seq = 0;
        run_seq(1'b0, -1, "restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule